// File: doc/BRIEF.md
# Single-Wire Bus Master Slot Generator

This block is the bit-level master side of an open-drain, single-wire serial bus. It runs from a system clock with a parameter giving the clock ticks per microsecond. Every bus timing point is given in microseconds and converted to ticks at elaboration. On a one-cycle command it produces one of four kinds of activity:
- a bus reset with detection of a slave's presence answer,
- a single write slot carrying a 0 or a 1,
- a single read slot,
- a full byte of eight slots, sent least significant bit first, with the byte read back.

The block pulls the line low through `line_oe` and reads it back through `line_i` via a two-flop synchroniser. A byte command may also ask for a strong pullup. The block then raises `spu_o` as soon as the last slot of that byte ends and holds it for a programmed number of microseconds. This keeps a parasite-powered slave supplied during a conversion or a non-volatile copy.

Top module: `sw_slot_master`

## Requirements
- R1: After reset, and whenever no command is in progress, `line_oe`, `busy`, `done` and `spu_o` are all 0.
- R2: A command is accepted only while `busy` is 0. `cmd_op` selects the command: 0 is bus reset, 1 is write bit with `cmd_data[0]` as the value, 2 is read bit, 3 is byte transfer with `cmd_data`. From the cycle after acceptance, a bus reset pulls `line_oe` high for RST_LOW_US×TICKS_PER_US cycles. It then releases the line for RST_WAIT_US×TICKS_PER_US cycles, with `busy` high the whole time.
- R3: During a bus reset, `presence` takes the inverse of the synchronised line, sampled PRES_SAMPLE_US×TICKS_PER_US cycles after the release. It reads 1 when a slave holds the line low at that point.
- R4: A write-0 slot pulls the line for SLOT_US×TICKS_PER_US cycles, then releases it for a recovery of REC_US×TICKS_PER_US cycles.
- R5: A write-1 slot pulls the line for W1_LOW_US×TICKS_PER_US cycles, then releases it for the rest of the (SLOT_US+REC_US)×TICKS_PER_US slot.
- R6: A read slot pulls the line for RD_LOW_US×TICKS_PER_US cycles and has the same total length as a write-1 slot. `rx_bit` gives the synchronised line value sampled RD_SAMPLE_US×TICKS_PER_US cycles after the slot starts.
- R7: A byte transfer runs eight back-to-back slots, `cmd_data[0]` first. A 1 bit uses a read slot and a 0 bit uses a write-0 slot. Bit i of `rx_byte` is the line value sampled in slot i.
- R8: `done` is a one-cycle pulse in the first cycle after the last slot, or after the reset wait. The result outputs are already valid in that cycle.
- R9: For a byte command with `cmd_spu` set and `spu_us` nonzero, `spu_o` is high from the cycle after the last slot for `spu_us`×TICKS_PER_US cycles. `busy` stays high during that time and `line_oe` stays low. With `spu_us` equal to 0, no pullup phase occurs.
- R10: A `cmd_valid` pulse while `busy` is high has no effect on the line waveform or on the outputs.
- R11: `line_oe` is never high for more than RST_LOW_US×TICKS_PER_US consecutive cycles.

Per-slot choice of read timing for 1 bits in byte mode lets one command both send and receive a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_op | input | 2 | 0 reset, 1 write bit, 2 read bit, 3 byte |
| cmd_data | input | 8 | Bit value (bit 0) or byte to send |
| cmd_spu | input | 1 | Request strong pullup after a byte |
| spu_us | input | SPU_W | Strong pullup duration in microseconds |
| line_i | input | 1 | Bus line level as seen at the pad |
| line_oe | output | 1 | 1 pulls the open-drain line low |
| spu_o | output | 1 | Strong pullup enable |
| busy | output | 1 | Command or pullup in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_bit | output | 1 | Last sampled bit of a bit command |
| rx_byte | output | 8 | Byte gathered by the last byte command |
| presence | output | 1 | Slave answered the last bus reset |

## Verification
The properties assume that `rst_n` is released synchronously and that `cmd_op` is one of its four codes whenever `cmd_valid` is high. They also assume that a slave only ever pulls the line low and lets it go well before the next slot begins. The bench meets these conditions with a behavioural slave. That slave answers only on a rising `line_oe`, or shortly after a reset release, and holds the line for a fixed 15 µs or 100 µs. The bench issues each new command only after the previous one has finished, except for the deliberate strobe sent during a busy slot.

// File: rtl/sw_slot_master.sv
module sw_slot_master #(
  parameter int TICKS_PER_US   = 8,
  parameter int RST_LOW_US     = 480,
  parameter int RST_WAIT_US    = 480,
  parameter int PRES_SAMPLE_US = 70,
  parameter int SLOT_US        = 70,
  parameter int REC_US         = 2,
  parameter int W1_LOW_US      = 6,
  parameter int RD_LOW_US      = 3,
  parameter int RD_SAMPLE_US   = 12,
  parameter int SPU_W          = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [7:0]       cmd_data,
  input  logic             cmd_spu,
  input  logic [SPU_W-1:0] spu_us,
  input  logic             line_i,
  output logic             line_oe,
  output logic             spu_o,
  output logic             busy,
  output logic             done,
  output logic             rx_bit,
  output logic [7:0]       rx_byte,
  output logic             presence
);
  localparam int CW = $clog2((RST_LOW_US + RST_WAIT_US) * TICKS_PER_US + 1);
  localparam int SW = SPU_W + $clog2(TICKS_PER_US + 1);
  localparam logic [CW-1:0] T_RST_LOW = CW'(RST_LOW_US * TICKS_PER_US);
  localparam logic [CW-1:0] T_RST_END = CW'((RST_LOW_US + RST_WAIT_US) * TICKS_PER_US - 1);
  localparam logic [CW-1:0] T_PRES    = CW'((RST_LOW_US + PRES_SAMPLE_US) * TICKS_PER_US);
  localparam logic [CW-1:0] T_SLOT_END= CW'((SLOT_US + REC_US) * TICKS_PER_US - 1);
  localparam logic [CW-1:0] T_W0      = CW'(SLOT_US * TICKS_PER_US);
  localparam logic [CW-1:0] T_W1      = CW'(W1_LOW_US * TICKS_PER_US);
  localparam logic [CW-1:0] T_RD      = CW'(RD_LOW_US * TICKS_PER_US);
  localparam logic [CW-1:0] T_SAMP    = CW'(RD_SAMPLE_US * TICKS_PER_US);

  typedef enum logic [1:0] {S_IDLE, S_RST, S_SLOT, S_SPU} state_t;
  typedef enum logic [1:0] {K_W0, K_W1, K_RD} kind_t;

  state_t        st;
  kind_t         kind;
  logic [CW-1:0] cnt;
  logic [CW-1:0] low_t;
  logic [2:0]    bidx;
  logic          is_byte;
  logic          spu_req;
  logic [SW-1:0] spu_left;
  logic [7:0]    tx;
  logic [7:0]    rxsh;
  logic          cap;
  logic [1:0]    sync;

  always_comb begin
    case (kind)
      K_W0:    low_t = T_W0;
      K_W1:    low_t = T_W1;
      default: low_t = T_RD;
    endcase
  end

  assign line_oe = (st == S_RST && cnt < T_RST_LOW) || (st == S_SLOT && cnt < low_t);
  assign busy    = (st != S_IDLE);
  assign spu_o   = (st == S_SPU);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      kind     <= K_W0;
      cnt      <= '0;
      bidx     <= '0;
      is_byte  <= 1'b0;
      spu_req  <= 1'b0;
      spu_left <= '0;
      tx       <= '0;
      rxsh     <= '0;
      cap      <= 1'b0;
      sync     <= 2'b11;
      done     <= 1'b0;
      rx_bit   <= 1'b0;
      rx_byte  <= '0;
      presence <= 1'b0;
    end else begin
      sync <= {sync[0], line_i};
      done <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          cnt     <= '0;
          bidx    <= '0;
          is_byte <= 1'b0;
          spu_req <= 1'b0;
          case (cmd_op)
            2'd0: st <= S_RST;
            2'd1: begin st <= S_SLOT; kind <= cmd_data[0] ? K_W1 : K_W0; end
            2'd2: begin st <= S_SLOT; kind <= K_RD; end
            default: begin
              st       <= S_SLOT;
              kind     <= cmd_data[0] ? K_RD : K_W0;
              tx       <= cmd_data;
              is_byte  <= 1'b1;
              spu_req  <= cmd_spu && (spu_us != '0);
              spu_left <= SW'(spu_us) * SW'(TICKS_PER_US);
            end
          endcase
        end
        S_RST: begin
          cnt <= cnt + 1'b1;
          if (cnt == T_PRES) presence <= ~sync[1];
          if (cnt == T_RST_END) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end
        S_SLOT: begin
          cnt <= cnt + 1'b1;
          if (cnt == T_SAMP) begin
            cap        <= sync[1];
            rxsh[bidx] <= sync[1];
          end
          if (cnt == T_SLOT_END) begin
            cnt <= '0;
            if (is_byte && bidx != 3'd7) begin
              bidx <= bidx + 3'd1;
              kind <= tx[bidx + 3'd1] ? K_RD : K_W0;
            end else begin
              done <= 1'b1;
              if (is_byte) rx_byte <= rxsh;
              else         rx_bit  <= cap;
              st <= (is_byte && spu_req) ? S_SPU : S_IDLE;
            end
          end
        end
        default: begin
          spu_left <= spu_left - 1'b1;
          if (spu_left == SW'(1)) st <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/sw_slot_master_chk.sv
module sw_slot_master_chk #(
  parameter int RUN_MAX = 3840
) (
  input logic clk,
  input logic rst_n,
  input logic line_oe,
  input logic busy,
  input logic done,
  input logic spu_o
);
  int unsigned run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 0;
    else        run <= line_oe ? run + 1 : 0;
  end

  p_low_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RUN_MAX);

  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_oe && !spu_o);

  p_spu_line_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    spu_o |-> !line_oe && busy);

  p_spu_starts_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spu_o) |-> done);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind sw_slot_master sw_slot_master_chk #(.RUN_MAX(RST_LOW_US * TICKS_PER_US)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_oe(line_oe), .busy(busy), .done(done), .spu_o(spu_o)
);

// File: tb/sim_sw_slot_master.sv
module sim_sw_slot_master;
  localparam int T      = 2;
  localparam int RLOW   = 480 * T;
  localparam int RALL   = 960 * T;
  localparam int SLOT   = 72 * T;
  localparam int W0LOW  = 70 * T;
  localparam int W1LOW  = 6 * T;
  localparam int RDLOW  = 3 * T;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_spu = 0;
  logic [1:0] cmd_op = 0;
  logic [7:0] cmd_data = 0;
  logic [15:0] spu_us = 0;
  logic line_oe, spu_o, busy, done, rx_bit, presence;
  logic [7:0] rx_byte;
  logic slave_low = 0;
  wire  line_i = !(line_oe || slave_low);

  int checks = 0, errors = 0, cycles = 0;

  sw_slot_master #(.TICKS_PER_US(T)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_spu(cmd_spu), .spu_us(spu_us), .line_i(line_i),
    .line_oe(line_oe), .spu_o(spu_o), .busy(busy), .done(done),
    .rx_bit(rx_bit), .rx_byte(rx_byte), .presence(presence));

  always #4 clk = ~clk;

  // Reference model: expected {line_oe, busy, done, spu_o} per cycle
  logic [3:0] mq[$];
  int         rq[$];
  logic [3:0] cur = 0;
  int         cur_r = 1;

  task automatic push_n(input int n, input int low, input int req);
    for (int i = 0; i < n; i++) begin
      mq.push_back({i < low, 1'b1, 1'b0, 1'b0});
      rq.push_back(req);
    end
  endtask

  always @(posedge clk) if (rst_n && cmd_valid && !cur[2]) begin
    case (cmd_op)
      2'd0: push_n(RALL, RLOW, 2);
      2'd1: push_n(SLOT, cmd_data[0] ? W1LOW : W0LOW, cmd_data[0] ? 5 : 4);
      2'd2: push_n(SLOT, RDLOW, 6);
      default: for (int b = 0; b < 8; b++) push_n(SLOT, cmd_data[b] ? RDLOW : W0LOW, 7);
    endcase
    if (cmd_op == 2'd3 && cmd_spu && spu_us != 0) begin
      for (int j = 0; j < spu_us * T; j++) begin
        mq.push_back({1'b0, 1'b1, j == 0, 1'b1});
        rq.push_back(9);
      end
    end else begin
      mq.push_back(4'b0010);
      rq.push_back(8);
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (mq.size() > 0) begin cur = mq.pop_front(); cur_r = rq.pop_front(); end
    else begin cur = 4'b0000; cur_r = 1; end
    checks++;
    if ({line_oe, busy, done, spu_o} !== cur) begin
      errors++;
      $display("FAIL R%0d cycle %0d: {oe,busy,done,spu} got %b expected %b",
               cur_r, cycles, {line_oe, busy, done, spu_o}, cur);
    end
  end

  // Behavioural slave
  int   sq[$];
  logic pres_arm = 0, oe_q = 0;
  int   hold = 0, pw = 0;
  always @(negedge clk) begin
    if (hold > 0) hold--;
    if (pw > 0) begin pw--; if (pw == 0) hold = 100 * T; end
    if (line_oe && !oe_q && sq.size() > 0) begin
      if (sq.pop_front() == 0) hold = 15 * T;
    end
    if (!line_oe && oe_q && pres_arm) pw = 20 * T;
    slave_low = hold > 0;
    oe_q = line_oe;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [7:0] d, input logic spu, input int us);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_data = d; cmd_spu = spu; spu_us = 16'(us);
    @(negedge clk);
    cmd_valid = 0; cmd_spu = 0;
  endtask

  task automatic finish_cmd();
    while (!done) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state after reset
    check("R1 line_oe", line_oe, 0);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 spu_o", spu_o, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R2 R3: bus reset with a slave answering
    pres_arm = 1;
    issue(2'd0, 8'h00, 0, 0);
    while (!done) @(negedge clk);
    check("R3 presence answered", presence, 1);
    pres_arm = 0;
    finish_cmd();
    // R3: no slave answers
    issue(2'd0, 8'h00, 0, 0);
    while (!done) @(negedge clk);
    check("R3 presence absent", presence, 0);
    finish_cmd();

    // R4 R5: write slots (waveform checked by model)
    issue(2'd1, 8'h00, 0, 0); finish_cmd();
    issue(2'd1, 8'h01, 0, 0); finish_cmd();

    // R6: read slots
    sq.push_back(0);
    issue(2'd2, 8'h00, 0, 0);
    while (!done) @(negedge clk);
    check("R6 read zero", rx_bit, 0);
    finish_cmd();
    sq.push_back(1);
    issue(2'd2, 8'h00, 0, 0);
    while (!done) @(negedge clk);
    check("R6 read one", rx_bit, 1);
    finish_cmd();

    // R7: byte transfers, LSB first
    for (int i = 0; i < 8; i++) sq.push_back(1);
    issue(2'd3, 8'hA5, 0, 0);
    while (!done) @(negedge clk);
    check("R7 byte A5 echo", rx_byte, 8'hA5);
    check("R8 done with busy low", busy, 0);
    finish_cmd();
    for (int i = 0; i < 8; i++) sq.push_back((8'h3C >> i) & 1);
    issue(2'd3, 8'hFF, 0, 0);
    while (!done) @(negedge clk);
    check("R7 byte read 3C", rx_byte, 8'h3C);
    finish_cmd();

    // R9: strong pullup after a byte, and none when duration is zero
    issue(2'd3, 8'h44, 1, 5);
    while (!done) @(negedge clk);
    check("R9 spu on at done", spu_o, 1);
    finish_cmd();
    issue(2'd3, 8'h48, 1, 0);
    while (!done) @(negedge clk);
    check("R9 no spu for zero", spu_o, 0);
    finish_cmd();

    // R10: strobe during a busy slot is ignored
    sq.push_back(0);
    issue(2'd2, 8'h00, 0, 0);
    repeat (10) @(negedge clk);
    cmd_valid = 1; cmd_op = 2'd0;
    @(negedge clk);
    cmd_valid = 0;
    while (!done) @(negedge clk);
    check("R10 read unaffected", rx_bit, 0);
    finish_cmd();
    check("R10 stays idle", busy, 0);
    // R11 is covered by the reset waveform and the run-length property
    check("R11 line released", line_oe, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule